// File: doc/BRIEF.md
# Fractional baud tick generator

This block turns a fast system clock (16 MHz in the intended use) into a single-cycle enable pulse at sixteen times a UART's baud rate. The rate is set by three values: a whole-number prescale count, a step value and a modulus. The prescaler divides the clock into enable strobes. On each strobe a phase accumulator adds the step, and whenever the total reaches the modulus it emits a tick and keeps only the remainder. The long-term tick rate is therefore exactly clk / prescale × step / modulus. With prescale 1 and modulus 625, a step of 3, 6, 12 or 36 gives the 16x tick for 4800, 9600, 19200 or 57600 baud with no rate error.

Each UART owns its own instance, so every instance has its own settings. Software presents the three values on the configuration inputs and pulses a load strobe. The load captures them and restarts both the prescaler and the accumulator from zero.

Top module: `frac_baud_tick`

## Requirements
- R1: After reset the stored settings are all zero and `tick_o` stays low until a valid setting is loaded.
- R2: A load (`cfg_load_i` high at a rising edge) captures the three settings, zeroes the prescaler count and the accumulator, and holds `tick_o` low in the following cycle. Any phase built up earlier is discarded.
- R3: With prescale value P, the accumulator is advanced at the P-th, 2P-th, 3P-th … rising edge after the load edge and at no other edge.
- R4: At each advance the step is added. If the total is at least the modulus, `tick_o` is high for the cycle after that edge and the total less the modulus is kept. Otherwise the total is kept and `tick_o` is low.
- R5: After N advances since a load, exactly floor(N × step / modulus) ticks have been produced.
- R6: If the prescale value, the step or the modulus is zero, no tick is produced.
- R7: If the step is larger than the modulus, the setting is invalid and no tick is produced.
- R8: If the step equals the modulus, every advance produces a tick.
- R9: `tick_o` is only ever high in the cycle after an advance edge, so two ticks are at least P cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Load strobe for the three settings |
| cfg_pre_i | input | PRE_W | Prescale count P |
| cfg_step_i | input | STEP_W | Accumulator step (multiplier) |
| cfg_mod_i | input | MOD_W | Accumulator modulus (second divider) |
| tick_o | output | 1 | Single-cycle 16x oversampling enable |

## Verification
On every cycle, the assertions check the following. The prescaler count stays below P. The accumulator stays below the modulus. A load leaves a zero phase and no tick. A tick only follows an advance. An invalid setting yields no tick, and an equal step and modulus ticks at every advance. Whether the ticks fall at the right edges and reach the right long-run count (the fractional carry, the exact 4800/9600 rates, the effect of a reload mid-run) can only be shown by the bench's scenarios. Those scenarios compare each cycle against an edge-count formula and count the ticks over long windows.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // A setting is usable when nothing is zero and the step does not exceed the modulus.
  function automatic logic cfg_ok(int unsigned pre, int unsigned step, int unsigned modv);
    return (pre != 0) && (step != 0) && (modv != 0) && (step <= modv);
  endfunction

  // Next phase given the current phase, the step and the modulus.
  function automatic int unsigned phase_next(int unsigned acc, int unsigned step,
                                             int unsigned modv);
    int unsigned s;
    s = acc + step;
    return (s >= modv) ? (s - modv) : s;
  endfunction

  // Whether an advance from this phase wraps, producing a tick.
  function automatic logic phase_wraps(int unsigned acc, int unsigned step,
                                       int unsigned modv);
    return (acc + step) >= modv;
  endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             en_o
);

  logic [PRE_W-1:0] cnt_q;
  logic             last_w;

  assign last_w = (div_i != '0) && (cnt_q == div_i - PRE_W'(1));
  assign en_o   = last_w && !clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (div_i == '0)    cnt_q <= '0;
    else if (last_w)         cnt_q <= '0;
    else                     cnt_q <= cnt_q + PRE_W'(1);
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i != '0) |-> (cnt_q < div_i));

  // R2
  pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/baud_phase_accum.sv
module baud_phase_accum
  import baud_tick_pkg::*;
#(
  parameter int STEP_W = 10,
  parameter int MOD_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [MOD_W-1:0]  mod_i,
  output logic              tick_o
);

  localparam int ACC_W = ((STEP_W > MOD_W) ? STEP_W : MOD_W) + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next_w;
  logic             wrap_w;
  logic             fire_w;

  assign wrap_w     = phase_wraps(32'(acc_q), 32'(step_i), 32'(mod_i));
  assign acc_next_w = ACC_W'(phase_next(32'(acc_q), 32'(step_i), 32'(mod_i)));
  assign fire_w     = en_i && valid_i && wrap_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (clear_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (en_i && valid_i) begin
      acc_q  <= acc_next_w;
      tick_o <= fire_w;
    end else begin
      tick_o <= 1'b0;
    end
  end

  // R4
  acc_below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> (acc_q < ACC_W'(mod_i)));

  // R2
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> ((acc_q == '0) && !tick_o));

endmodule

// File: rtl/frac_baud_tick.sv
module frac_baud_tick
  import baud_tick_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int STEP_W = 10,
  parameter int MOD_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load_i,
  input  logic [PRE_W-1:0]  cfg_pre_i,
  input  logic [STEP_W-1:0] cfg_step_i,
  input  logic [MOD_W-1:0]  cfg_mod_i,
  output logic              tick_o
);

  logic [PRE_W-1:0]  pre_q;
  logic [STEP_W-1:0] step_q;
  logic [MOD_W-1:0]  mod_q;
  logic              cfg_valid_w;
  logic              adv_en_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
      mod_q  <= '0;
    end else if (cfg_load_i) begin
      pre_q  <= cfg_pre_i;
      step_q <= cfg_step_i;
      mod_q  <= cfg_mod_i;
    end
  end

  assign cfg_valid_w = cfg_ok(32'(pre_q), 32'(step_q), 32'(mod_q));

  baud_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (cfg_load_i),
    .div_i   (pre_q),
    .en_o    (adv_en_w)
  );

  baud_phase_accum #(.STEP_W(STEP_W), .MOD_W(MOD_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (cfg_load_i),
    .en_i    (adv_en_w),
    .valid_i (cfg_valid_w),
    .step_i  (step_q),
    .mod_i   (mod_q),
    .tick_o  (tick_o)
  );

  // R9
  tick_after_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(adv_en_w));

  // R6 R7
  no_tick_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid_w |=> !tick_o);

  // R8
  equal_step_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid_w && (32'(step_q) == 32'(mod_q)) && adv_en_w && !cfg_load_i) |=> tick_o);

endmodule

// File: tb/frac_baud_tick_test.sv
`timescale 1ns/1ps
module frac_baud_tick_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 1'b0;
  logic [7:0] cfg_pre = '0;
  logic [9:0] cfg_step = '0;
  logic [9:0] cfg_mod = '0;
  logic       tick;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  frac_baud_tick uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load_i (cfg_load),
    .cfg_pre_i  (cfg_pre),
    .cfg_step_i (cfg_step),
    .cfg_mod_i  (cfg_mod),
    .tick_o     (tick)
  );

  // Reference: tick after edge n since load iff n is a multiple of P and
  // floor(k*step/mod) grew at advance k = n/P.
  longint n_edges = 0;
  longint m_pre = 0, m_step = 0, m_mod = 0;
  bit     exp_tick = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_edges = 0; m_pre = 0; m_step = 0; m_mod = 0; exp_tick = 1'b0;
    end else if (cfg_load) begin
      m_pre = cfg_pre; m_step = cfg_step; m_mod = cfg_mod;
      n_edges = 0; exp_tick = 1'b0;
    end else begin
      n_edges = n_edges + 1;
      if (m_pre != 0 && m_step != 0 && m_mod != 0 && m_step <= m_mod
          && (n_edges % m_pre) == 0) begin
        longint k;
        k = n_edges / m_pre;
        exp_tick = ((k * m_step) / m_mod) != (((k - 1) * m_step) / m_mod);
      end else begin
        exp_tick = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (tick !== exp_tick) begin
      errors++;
      $display("FAIL %s: cycle compare tick=%0b expected=%0b at edge %0d",
               cur_req, tick, exp_tick, n_edges);
    end
  end

  task automatic check_count(string req, int got, int want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s: tick count %0d expected %0d", req, got, want);
    end
  endtask

  task automatic run_cfg(string req, int p, int s, int m, int cycles);
    int cnt = 0;
    int want;
    cur_req = req;
    @(negedge clk);
    cfg_load = 1'b1; cfg_pre = 8'(p); cfg_step = 10'(s); cfg_mod = 10'(m);
    @(negedge clk);
    cfg_load = 1'b0;
    repeat (cycles) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    if (p != 0 && s != 0 && m != 0 && s <= m) want = ((cycles / p) * s) / m;
    else want = 0;
    check_count(req, cnt, want);
  endtask

  initial begin
    int cnt = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (tick !== 1'b0) begin
      errors++;
      $display("FAIL R1: tick in reset %0b expected 0", tick);
    end
    rst_n = 1'b1;
    repeat (50) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    check_count("R1", cnt, 0);

    run_cfg("R5", 1, 6, 625, 5000);    // 9600 baud: 48
    run_cfg("R5", 1, 3, 625, 5000);    // 4800 baud: 24
    run_cfg("R3", 3, 12, 625, 6000);   // prescale 3: 38
    run_cfg("R4", 2, 36, 625, 4000);   // carry of remainder: 115
    run_cfg("R6", 0, 6, 625, 500);
    run_cfg("R6", 1, 0, 625, 500);
    run_cfg("R6", 1, 6, 0, 500);
    run_cfg("R7", 1, 700, 625, 500);
    run_cfg("R8", 4, 10, 10, 100);     // 25
    run_cfg("R9", 5, 625, 625, 50);    // ticks every 5 cycles: 10

    // R2: phase built up, then reload; a stale phase would tick early
    run_cfg("R2", 1, 6, 625, 100);
    run_cfg("R2", 1, 6, 625, 104);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule